// File: doc/BRIEF.md
# Priority-Gated CSMA/CA Access Controller

This block decides when a station may start transmitting on a shared medium during the contention period. It watches a carrier-sense input. Each time the medium falls idle, it walks through three timed phases. The first is an inter-frame guard. The second is a reserved window in which only the upper priority class may count down its random backoff. The third is an open contention window in which every pending frame may count down. All timing is measured in slots of `SLOT_CYCLES` clocks.

A client offers one frame at a time. The offer carries a 4-bit priority, so there are sixteen levels. A programmable threshold splits those levels into an upper class and a lower class. When the frame is accepted, the block loads a random backoff, masked by the contention window. The block answers with a single-cycle transmit grant. Any carrier detected along the way freezes the backoff and sends the phase sequence back to the guard interval. When the token-passing access mode is selected, this scheme is switched off completely.

Top module: `prio_csma_arbiter`

## Requirements
- R1: While reset is asserted and right after it, `tx_grant` is 0 and `req_ready` is 1.
- R2: Slot and phase timing:
  - A slot lasts `SLOT_CYCLES` clocks.
  - After the medium is idle (`carrier_sense` and `vt_mode` both 0) at clock edge E0, the guard phase lasts `cifs_slots` slots, the reserved phase lasts `gap_slots` slots, and then the open phase holds until the medium is busy again.
  - A length of zero counts as one slot.
- R3: A frame whose priority is at or above `prio_thresh` belongs to the upper class. With a zero backoff, it is granted in the cycle after edge E0 + `cifs_slots`*`SLOT_CYCLES` + 1.
- R4: A lower-class frame does not count backoff and is never granted during the reserved phase. With a zero backoff, it is granted in the cycle after edge E0 + (`cifs_slots`+`gap_slots`)*`SLOT_CYCLES` + 1.
- R5: Backoff loading and countdown:
  - On acceptance, the backoff is loaded with a pseudo-random value ANDed with `cw_mask`.
  - It decrements by one at each slot boundary while the frame is eligible and the medium is idle.
  - A backoff of n therefore moves the grant n slots later than the zero-backoff time of R3 or R4.
- R6: A busy medium in any phase freezes the backoff. The phase sequence restarts from the guard interval when the medium is idle again.
- R7: `tx_grant` is high for exactly one cycle. It is only given when the medium was idle and `req_valid` was high in the preceding cycle, and it consumes the held frame.
- R8: Request handshake and withdrawal:
  - `req_ready` is 1 exactly when no frame is held.
  - A frame is accepted on `req_valid` && `req_ready`, and its priority is captured at that moment.
  - Dropping `req_valid` while a frame is held withdraws it with no grant, and `req_ready` returns to 1.
- R9: While `vt_mode` is 1, no grant is issued and the backoff does not count. Clearing `vt_mode` restarts the sequence from the guard interval.
- R10: All 16 priority levels are compared against the threshold. For example, level 7 with threshold 8 is lower class, and level 15 with threshold 15 is upper class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| carrier_sense | input | 1 | Medium busy indication |
| vt_mode | input | 1 | Token-passing access mode active; disables this scheme |
| prio_thresh | input | PRIO_W | Lowest priority counted as upper class |
| cifs_slots | input | LEN_W | Guard interval length in slots |
| gap_slots | input | LEN_W | Reserved phase length in slots |
| cw_mask | input | BO_W | Contention window mask applied to the random backoff |
| req_valid | input | 1 | Frame pending; drop to withdraw |
| req_prio | input | PRIO_W | Priority of the offered frame |
| req_ready | output | 1 | No frame held; a new offer is taken |
| tx_grant | output | 1 | One-cycle permission to transmit |

## Verification
On every cycle, the assertions check four things:
- the grant is a one-cycle pulse that only follows an idle, requested cycle;
- carrier or token mode forces the busy phase and freezes the backoff;
- a lower-class frame neither counts nor wins during the reserved phase;
- the reserved phase is only entered from the guard phase.

Only the bench scenarios can show exact grant cycles. Those scenarios cover each class, zero-length intervals, randomized windows with slot alignment, restart after an interrupted reserved phase, withdrawal, and recovery from token mode.

// File: rtl/prio_csma_pkg.sv
package prio_csma_pkg;
  typedef enum logic [1:0] {
    MED_BUSY = 2'd0,
    MED_CIFS = 2'd1,
    MED_GAP  = 2'd2,
    MED_CONT = 2'd3
  } med_state_e;
endpackage

// File: rtl/csma_lfsr.sv
module csma_lfsr #(
  parameter int          W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] value
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= SEED;
    else if (value[0]) value <= (value >> 1) ^ TAPS;
    else value <= value >> 1;
  end
endmodule

// File: rtl/csma_medium_fsm.sv
module csma_medium_fsm
  import prio_csma_pkg::*;
#(
  parameter int SLOT_CYCLES = 8,
  parameter int LEN_W       = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             blocked,
  input  logic [LEN_W-1:0] cifs_len,
  input  logic [LEN_W-1:0] gap_len,
  output med_state_e       state,
  output logic             slot_tick
);
  localparam int SC_W = (SLOT_CYCLES > 1) ? $clog2(SLOT_CYCLES) : 1;

  logic [LEN_W-1:0] phase_cnt;
  logic             phase_last;
  logic [LEN_W-1:0] cur_len;

  // slot timer: a parameter picks a trivial or counting variant
  generate
    if (SLOT_CYCLES == 1) begin : g_unit_slot
      assign slot_tick = (state != MED_BUSY);
    end else begin : g_count_slot
      logic [SC_W-1:0] slot_cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_cnt <= '0;
        else if (blocked || state == MED_BUSY) slot_cnt <= '0;
        else if (slot_cnt == SC_W'(SLOT_CYCLES - 1)) slot_cnt <= '0;
        else slot_cnt <= slot_cnt + 1'b1;
      end
      assign slot_tick = (state != MED_BUSY) && (slot_cnt == SC_W'(SLOT_CYCLES - 1));
    end
  endgenerate

  assign cur_len    = (state == MED_CIFS) ? cifs_len : gap_len;
  assign phase_last = ({1'b0, phase_cnt} + 1'b1) >= {1'b0, cur_len};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= MED_BUSY;
      phase_cnt <= '0;
    end else if (blocked) begin
      state     <= MED_BUSY;
      phase_cnt <= '0;
    end else begin
      unique case (state)
        MED_BUSY: begin
          state     <= MED_CIFS;
          phase_cnt <= '0;
        end
        MED_CIFS, MED_GAP: begin
          if (slot_tick) begin
            if (phase_last) begin
              state     <= (state == MED_CIFS) ? MED_GAP : MED_CONT;
              phase_cnt <= '0;
            end else begin
              phase_cnt <= phase_cnt + 1'b1;
            end
          end
        end
        default: phase_cnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/csma_backoff.sv
module csma_backoff #(
  parameter int BO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [BO_W-1:0] load_val,
  input  logic            step,
  output logic [BO_W-1:0] count,
  output logic            zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else if (load) count <= load_val;
    else if (step && count != '0) count <= count - 1'b1;
  end
  assign zero = (count == '0);
endmodule

// File: rtl/prio_csma_arbiter.sv
module prio_csma_arbiter
  import prio_csma_pkg::*;
#(
  parameter int SLOT_CYCLES = 8,
  parameter int PRIO_W      = 4,
  parameter int LEN_W       = 4,
  parameter int BO_W        = 8,
  parameter int RND_W       = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              carrier_sense,
  input  logic              vt_mode,
  input  logic [PRIO_W-1:0] prio_thresh,
  input  logic [LEN_W-1:0]  cifs_slots,
  input  logic [LEN_W-1:0]  gap_slots,
  input  logic [BO_W-1:0]   cw_mask,
  input  logic              req_valid,
  input  logic [PRIO_W-1:0] req_prio,
  output logic              req_ready,
  output logic              tx_grant
);
  logic             blocked;
  med_state_e       med_state;
  logic             slot_tick;
  logic [RND_W-1:0] rnd;
  logic             held_q;
  logic             hi_q;
  logic             accept;
  logic             eligible;
  logic             grant_d;
  logic [BO_W-1:0]  bo_count;
  logic             bo_zero;

  assign blocked = carrier_sense | vt_mode;

  csma_medium_fsm #(.SLOT_CYCLES(SLOT_CYCLES), .LEN_W(LEN_W)) u_medium (
    .clk       (clk),
    .rst_n     (rst_n),
    .blocked   (blocked),
    .cifs_len  (cifs_slots),
    .gap_len   (gap_slots),
    .state     (med_state),
    .slot_tick (slot_tick)
  );

  csma_lfsr #(.W(RND_W)) u_rand (
    .clk   (clk),
    .rst_n (rst_n),
    .value (rnd)
  );

  assign accept   = req_valid && !held_q;
  assign eligible = held_q && ((med_state == MED_GAP && hi_q) || med_state == MED_CONT);
  assign grant_d  = eligible && bo_zero && !blocked && req_valid;

  csma_backoff #(.BO_W(BO_W)) u_backoff (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (rnd[BO_W-1:0] & cw_mask),
    .step     (slot_tick && eligible && !blocked),
    .count    (bo_count),
    .zero     (bo_zero)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q   <= 1'b0;
      hi_q     <= 1'b0;
      tx_grant <= 1'b0;
    end else begin
      tx_grant <= grant_d;
      if (grant_d || (held_q && !req_valid)) begin
        held_q <= 1'b0;
      end else if (accept) begin
        held_q <= 1'b1;
        hi_q   <= (req_prio >= prio_thresh);
      end
    end
  end

  assign req_ready = !held_q;
endmodule

// File: rtl/prio_csma_arbiter_chk.sv
module prio_csma_arbiter_chk
  import prio_csma_pkg::*;
#(
  parameter int BO_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            carrier_sense,
  input logic            vt_mode,
  input logic            req_valid,
  input logic            tx_grant,
  input logic            held,
  input logic            hi,
  input med_state_e      mstate,
  input logic [BO_W-1:0] bo
);
  p_grant_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |=> !tx_grant);

  p_grant_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> $past(!carrier_sense && !vt_mode && req_valid));

  p_token_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    vt_mode |=> !tx_grant);

  p_busy_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_sense |=> mstate == MED_BUSY);

  p_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (held && carrier_sense) |=> bo == $past(bo));

  p_low_no_count_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !hi && mstate == MED_GAP) |=> bo == $past(bo));

  p_low_no_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (held && !hi && mstate == MED_GAP) |=> !tx_grant);

  p_gap_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mstate == MED_GAP) |-> ($past(mstate) == MED_CIFS || $past(mstate) == MED_GAP));
endmodule

bind prio_csma_arbiter prio_csma_arbiter_chk #(.BO_W(BO_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .carrier_sense (carrier_sense),
  .vt_mode       (vt_mode),
  .req_valid     (req_valid),
  .tx_grant      (tx_grant),
  .held          (held_q),
  .hi            (hi_q),
  .mstate        (med_state),
  .bo            (bo_count)
);

// File: tb/prio_csma_arbiter_test.sv
module prio_csma_arbiter_test;
  localparam int S = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       carrier_sense = 1'b1;
  logic       vt_mode = 1'b0;
  logic [3:0] prio_thresh = 4'd8;
  logic [3:0] cifs_slots = 4'd2;
  logic [3:0] gap_slots = 4'd3;
  logic [7:0] cw_mask = 8'd0;
  logic       req_valid = 1'b0;
  logic [3:0] req_prio = 4'd0;
  logic       req_ready;
  logic       tx_grant;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int grants = 0;
  logic grant_prev = 1'b0;
  logic done = 1'b0;

  typedef struct {
    int    lo;
    int    hi;
    string tag;
  } exp_t;
  exp_t expq[$];

  prio_csma_arbiter uut (
    .clk(clk), .rst_n(rst_n), .carrier_sense(carrier_sense), .vt_mode(vt_mode),
    .prio_thresh(prio_thresh), .cifs_slots(cifs_slots), .gap_slots(gap_slots),
    .cw_mask(cw_mask), .req_valid(req_valid), .req_prio(req_prio),
    .req_ready(req_ready), .tx_grant(tx_grant)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: pops expected grant windows and compares
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (grant_prev) check(!tx_grant, "R7 pulse width", int'(tx_grant), 0);
      if (tx_grant) begin
        grants++;
        if (expq.size() == 0) begin
          check(1'b0, "R7 unexpected grant", cyc, -1);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(cyc >= e.lo && cyc <= e.hi && ((cyc - e.lo) % S) == 0, e.tag, cyc, e.lo);
        end
      end
      grant_prev = tx_grant;
    end
  end

  task automatic wait_grant(input int tmo, input string tag);
    int n = 0;
    while (!tx_grant && n < tmo) begin
      @(negedge clk);
      n++;
    end
    if (!tx_grant) check(1'b0, tag, 0, 1);
    req_valid = 1'b0;
  endtask

  task automatic run_case(input logic [3:0] p, input logic [3:0] thr, input logic [7:0] mask,
                          input int lo_off, input int hi_off, input string tag);
    int e0;
    @(negedge clk);
    carrier_sense = 1'b1;
    prio_thresh = thr;
    cw_mask = mask;
    req_prio = p;
    req_valid = 1'b1;
    repeat (3) @(negedge clk);
    check(req_ready == 1'b0, "R8 held frame drops ready", int'(req_ready), 0);
    carrier_sense = 1'b0;
    e0 = cyc + 1;
    expq.push_back('{e0 + lo_off, e0 + hi_off, tag});
    wait_grant(400, tag);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(tx_grant == 1'b0, "R1 grant low in reset", int'(tx_grant), 0);
    check(req_ready == 1'b1, "R1 ready high in reset", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_grant == 1'b0 && req_ready == 1'b1, "R1 state after reset", int'(tx_grant), 0);

    // upper class, zero backoff: guard 2 slots then grant
    run_case(4'd8, 4'd8, 8'd0, 2*S + 1, 2*S + 1, "R3 upper class zero backoff");
    // lower class waits out the reserved phase
    run_case(4'd7, 4'd8, 8'd0, 5*S + 1, 5*S + 1, "R4 R10 lower class zero backoff");
    // top level at top threshold is upper class
    run_case(4'd15, 4'd15, 8'd0, 2*S + 1, 2*S + 1, "R10 level 15 threshold 15");
    // random backoff windows
    run_case(4'd9, 4'd8, 8'd3, 2*S + 1, 5*S + 1, "R5 upper random window");
    run_case(4'd1, 4'd8, 8'd7, 5*S + 1, 12*S + 1, "R5 lower random window");
    run_case(4'd3, 4'd8, 8'd1, 5*S + 1, 6*S + 1, "R5 lower mask one");

    // zero-length intervals count as one slot
    cifs_slots = 4'd0;
    gap_slots = 4'd0;
    run_case(4'd12, 4'd8, 8'd0, S + 1, S + 1, "R2 zero lengths upper");
    run_case(4'd2, 4'd8, 8'd0, 2*S + 1, 2*S + 1, "R2 zero lengths lower");
    cifs_slots = 4'd2;
    gap_slots = 4'd3;

    // carrier during the reserved phase restarts from the guard
    begin
      int e1;
      @(negedge clk);
      carrier_sense = 1'b1;
      prio_thresh = 4'd8;
      cw_mask = 8'd0;
      req_prio = 4'd2;
      req_valid = 1'b1;
      repeat (3) @(negedge clk);
      carrier_sense = 1'b0;
      repeat (25) @(negedge clk);
      carrier_sense = 1'b1;
      repeat (3) @(negedge clk);
      carrier_sense = 1'b0;
      e1 = cyc + 1;
      expq.push_back('{e1 + 5*S + 1, e1 + 5*S + 1, "R6 restart after carrier"});
      wait_grant(400, "R6 restart after carrier");
      repeat (2) @(negedge clk);
    end

    // token mode blocks grants; clearing it restarts the sequence
    begin
      int e2;
      int g0;
      @(negedge clk);
      carrier_sense = 1'b1;
      req_prio = 4'd9;
      req_valid = 1'b1;
      repeat (3) @(negedge clk);
      vt_mode = 1'b1;
      carrier_sense = 1'b0;
      g0 = grants;
      repeat (80) @(negedge clk);
      check(grants == g0 && !tx_grant, "R9 no grant in token mode", grants - g0, 0);
      vt_mode = 1'b0;
      e2 = cyc + 1;
      expq.push_back('{e2 + 2*S + 1, e2 + 2*S + 1, "R9 grant after token mode"});
      wait_grant(400, "R9 grant after token mode");
      repeat (2) @(negedge clk);
    end

    // withdrawal: no grant, ready returns
    begin
      int g1;
      @(negedge clk);
      carrier_sense = 1'b1;
      req_prio = 4'd4;
      req_valid = 1'b1;
      repeat (3) @(negedge clk);
      check(req_ready == 1'b0, "R8 accepted", int'(req_ready), 0);
      req_valid = 1'b0;
      repeat (2) @(negedge clk);
      check(req_ready == 1'b1, "R8 ready after withdraw", int'(req_ready), 1);
      g1 = grants;
      carrier_sense = 1'b0;
      repeat (80) @(negedge clk);
      check(grants == g1, "R8 no grant after withdraw", grants - g1, 0);
    end

    check(expq.size() == 0, "R7 all grants seen", expq.size(), 0);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule